// File: doc/BRIEF.md
# Seven-Source Vectored Interrupt Controller

This block collects interrupt requests from seven sources and turns them into a single interrupt line and a vector address for a small CPU. The sources are a watchdog, two external port events, a serial port and three time-base ticks (32 Hz, 16 Hz and 1 Hz). Each request arrives as a one-cycle pulse and is latched into its own pending flag. The flag stays set until the CPU accepts that source or software clears it.

The watchdog source cannot be masked. The other six sources need two things: their own enable bit and a shared master enable. Among the eligible sources, the controller presents the one with the highest priority, together with its fixed vector. When the CPU acknowledges, the controller clears that source's pending flag. Accepting a maskable source also clears the master enable, so its handler is not entered again until software re-arms it.

Software reaches the enables and the pending flags through a small write port. That port has a 2-bit register selector and a 4-bit data field.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all pending flags, all enable bits and the master enable are 0. `irq_o` is 0 and `vec_o` is 0.
- R2: A one-cycle pulse on `req_i[k]` sets `pend_o[k]` at the next clock edge. The flag then holds, whether or not its source is enabled, until it is accepted or cleared. Source indices are: 0 watchdog, 1 external-0, 2 serial, 3 external-1, 4 32 Hz tick, 5 16 Hz tick, 6 1 Hz tick.
- R3: A pending watchdog flag (index 0) raises `irq_o` with vector 0x3B, whatever the master enable and the enable bits hold.
- R4: A pending maskable source k (1 to 6) is eligible only while the master enable is 1 and its enable bit is 1. The enable bits are set by these writes:
  - Selector 0 writes the enables of sources 1 to 4 from data bits 0 to 3.
  - Selector 1 writes the enables of sources 5 and 6 from data bits 0 and 1. Data bits 3:2 of this write are ignored.
  - Selector 2 writes the master enable from data bit 0.
- R5: The vectors are 0x38 for index 1, 0x35 for index 2, 0x32 for index 3, 0x29 for index 4, 0x26 for index 5 and 0x23 for index 6. `vec_o` is 0 whenever `irq_o` is 0.
- R6: When several sources are eligible, the lowest index wins, so the watchdog has the highest priority and the 1 Hz tick the lowest.
- R7: `ack_i` high while `irq_o` is high clears, at that edge, only the pending flag of the presented source.
- R8: Accepting a maskable source clears the master enable at the same edge, even if software writes the master enable in that cycle. Accepting the watchdog leaves the master enable unchanged.
- R9: `ack_i` while `irq_o` is 0 has no effect.
- R10: A write with selector 3 clears the pending flag whose index is in data bits 2:0. Index 7 has no effect. A request arriving in the same cycle as a clear of the same flag wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 7 | One-cycle request pulses, index 0 watchdog to 6 the 1 Hz tick |
| sw_we_i | input | 1 | Software write strobe |
| sw_sel_i | input | 2 | Write target: 0 low enables, 1 high enables, 2 master enable, 3 pending clear |
| sw_wdata_i | input | 4 | Write data |
| ack_i | input | 1 | CPU accepts the presented interrupt |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Vector address of the presented source, 0 when idle |
| pend_o | output | 7 | Pending flags |
| mie_o | output | 1 | Master enable state |

## Verification
Each piece of internal state shows up at the ports in the cycle right after the edge that changed it, because `irq_o` and `vec_o` are decoded combinationally from registers:
- A dropped or sticky pending flag shows on `pend_o`.
- A wrong enable or master-enable value shows as `irq_o` asserting when it should not, or staying low when it should assert.
- A wrong priority pick or a wrong vector entry shows as a wrong `vec_o` value.

The directed scenarios therefore check every port one cycle after each stimulus. They put several sources pending at once to expose the priority order and the clearing of the wrong flag on accept.

// File: rtl/irqv_pkg.sv
// Package: shared constants, the write-selector encoding and the vector
// lookup for the seven-source interrupt controller.
// Assumes index 0 is the non-maskable source and lower index = higher priority.
package irqv_pkg;
    localparam int NSRC  = 7;
    localparam int NMASK = NSRC - 1;
    localparam int VEC_W = 8;
    localparam int REG_W = 4;
    localparam int IDX_W = $clog2(NSRC);

    typedef enum logic [1:0] {
        SEL_EN_LO  = 2'd0,
        SEL_EN_HI  = 2'd1,
        SEL_MASTER = 2'd2,
        SEL_CLEAR  = 2'd3
    } sw_sel_e;

    // Vector of a source index: two descending runs spaced by three.
    function automatic logic [VEC_W-1:0] vec_of(input int idx);
        int v;
        if (idx < 4) v = 'h3B - 3 * idx;
        else         v = 'h29 - 3 * (idx - 4);
        return VEC_W'(v);
    endfunction
endpackage

// File: rtl/irqv_pending.sv
// Module: bank of pending flags, one per source.
// Assumes requests are single-cycle pulses; a request beats a clear in the same cycle.
module irqv_pending #(
    parameter int N = irqv_pkg::NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // Set on request, drop on clear, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)          pend_o[g] <= 1'b0;
            else if (req_i[g])   pend_o[g] <= 1'b1;
            else if (clr_i[g])   pend_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irqv_mask.sv
// Module: per-source enable registers and master enable; produces the
// per-source allow vector (index 0 always allowed).
// Assumes accepting a maskable source takes precedence over a master-enable write.
module irqv_mask
    import irqv_pkg::*;
#(
    parameter int N = NSRC,
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_we_i,
    input  logic [1:0]   sw_sel_i,
    input  logic [W-1:0] sw_wdata_i,
    input  logic         take_mask_i,
    output logic         mie_o,
    output logic [N-1:0] allow_o
);
    localparam int NM   = N - 1;
    localparam int HI_W = NM - W;

    logic [W-1:0]    en_lo;
    logic [HI_W-1:0] en_hi;
    logic [NM-1:0]   en_all;

    // Enable register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_lo <= '0;
            en_hi <= '0;
        end else if (sw_we_i) begin
            if (sw_sel_i == SEL_EN_LO) en_lo <= sw_wdata_i;
            if (sw_sel_i == SEL_EN_HI) en_hi <= sw_wdata_i[HI_W-1:0];
        end
    end

    // Master enable: cleared by a maskable accept, else software-written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mie_o <= 1'b0;
        else if (take_mask_i)
            mie_o <= 1'b0;
        else if (sw_we_i && sw_sel_i == SEL_MASTER)
            mie_o <= sw_wdata_i[0];
    end

    // Combine enables with the master flag; index 0 bypasses both.
    always_comb begin
        en_all  = {en_hi, en_lo};
        allow_o = {en_all & {NM{mie_o}}, 1'b1};
    end
endmodule

// File: rtl/irqv_arbiter.sv
// Module: fixed-priority pick among eligible sources and vector lookup.
// Assumes lower index means higher priority; vector is zero when nothing is eligible.
module irqv_arbiter
    import irqv_pkg::*;
#(
    parameter int N = NSRC,
    parameter int V = VEC_W
) (
    input  logic [N-1:0] elig_i,
    output logic         any_o,
    output logic [N-1:0] grant_o,
    output logic [V-1:0] vec_o
);
    // Scan from lowest priority up so the lowest index is left standing.
    always_comb begin
        grant_o = '0;
        vec_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                vec_o      = V'(vec_of(i));
            end
        end
        any_o = |elig_i;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: top of the vectored interrupt controller. Latches request pulses,
// gates the maskable ones, presents the winning vector and clears on accept.
// Assumes the CPU holds ack_i for one cycle per accept and samples vec_o with it.
module irq_vector_ctrl
    import irqv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    req_i,
    input  logic               sw_we_i,
    input  logic [1:0]         sw_sel_i,
    input  logic [REG_W-1:0]   sw_wdata_i,
    input  logic               ack_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [NSRC-1:0]    pend_o,
    output logic               mie_o
);
    logic [NSRC-1:0] allow;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] grant;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] sw_clr;
    logic [IDX_W-1:0] clr_idx;
    logic            take;
    logic            take_mask;

    irqv_pending #(.N(NSRC)) pend_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .clr_i  (clr),
        .pend_o (pend_o)
    );

    irqv_mask #(.N(NSRC), .W(REG_W)) mask_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_we_i     (sw_we_i),
        .sw_sel_i    (sw_sel_i),
        .sw_wdata_i  (sw_wdata_i),
        .take_mask_i (take_mask),
        .mie_o       (mie_o),
        .allow_o     (allow)
    );

    irqv_arbiter #(.N(NSRC), .V(VEC_W)) arb_i (
        .elig_i  (elig),
        .any_o   (irq_o),
        .grant_o (grant),
        .vec_o   (vec_o)
    );

    // Eligibility, accept detection and clear vector.
    always_comb begin
        elig      = pend_o & allow;
        take      = ack_i & irq_o;
        take_mask = take & ~grant[0];
        clr_idx   = sw_wdata_i[IDX_W-1:0];
        sw_clr    = '0;
        if (sw_we_i && sw_sel_i == SEL_CLEAR && int'(clr_idx) < NSRC)
            sw_clr[clr_idx] = 1'b1;
        clr = (take ? grant : '0) | sw_clr;
    end
endmodule

// File: rtl/irqv_chk.sv
// Module: assertion checker for irq_vector_ctrl, attached by bind.
module irqv_chk
    import irqv_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NSRC-1:0]    req_i,
    input logic               sw_we_i,
    input logic               ack_i,
    input logic               irq_o,
    input logic [VEC_W-1:0]   vec_o,
    input logic [NSRC-1:0]    pend_o,
    input logic               mie_o
);
    // R2
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !sw_we_i) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

    // R3
    nmi_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o[0] |-> (irq_o && vec_o == 8'h3B));

    // R4
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mie_o && !pend_o[0]) |-> !irq_o);

    // R5
    idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec_o == '0));

    // R7
    nmi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && vec_o == 8'h3B && !req_i[0]) |=> !pend_o[0]);

    // R8
    mie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && vec_o != 8'h3B) |=> !mie_o);
endmodule

bind irq_vector_ctrl irqv_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .sw_we_i (sw_we_i),
    .ack_i   (ack_i),
    .irq_o   (irq_o),
    .vec_o   (vec_o),
    .pend_o  (pend_o),
    .mie_o   (mie_o)
);

// File: tb/irq_vector_ctrl_tb.sv
// Directed bench for irq_vector_ctrl: one task per scenario.
module irq_vector_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] req_i = '0;
    logic       sw_we_i = 1'b0;
    logic [1:0] sw_sel_i = '0;
    logic [3:0] sw_wdata_i = '0;
    logic       ack_i = 1'b0;
    logic       irq_o;
    logic [7:0] vec_o;
    logic [6:0] pend_o;
    logic       mie_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [7:0] exp_vec [7] = '{8'h3B, 8'h38, 8'h35, 8'h32, 8'h29, 8'h26, 8'h23};

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .sw_we_i    (sw_we_i),
        .sw_sel_i   (sw_sel_i),
        .sw_wdata_i (sw_wdata_i),
        .ack_i      (ack_i),
        .irq_o      (irq_o),
        .vec_o      (vec_o),
        .pend_o     (pend_o),
        .mie_o      (mie_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [3:0] data);
        sw_we_i = 1'b1; sw_sel_i = sel; sw_wdata_i = data;
        tick();
        sw_we_i = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] m);
        req_i = m;
        tick();
        req_i = '0;
    endtask

    task automatic accept();
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 pend", 32'(pend_o), 0);
        check("R1 irq", 32'(irq_o), 0);
        check("R1 mie", 32'(mie_o), 0);
        check("R1 vec", 32'(vec_o), 0);
    endtask

    task automatic t_hold_then_take();
        pulse(7'h02);
        check("R2 set", 32'(pend_o), 32'h02);
        check("R2 masked irq", 32'(irq_o), 0);
        repeat (3) tick();
        check("R2 hold", 32'(pend_o), 32'h02);
        wr(2'd0, 4'h1);
        check("R4 mie off", 32'(irq_o), 0);
        wr(2'd2, 4'h1);
        check("R4 enabled irq", 32'(irq_o), 1);
        check("R5 ext0 vec", 32'(vec_o), 32'h38);
        accept();
        check("R7 cleared", 32'(pend_o), 0);
        check("R8 mie dropped", 32'(mie_o), 0);
        check("R5 idle vec", 32'(vec_o), 0);
    endtask

    task automatic t_nmi();
        pulse(7'h01);
        check("R3 irq", 32'(irq_o), 1);
        check("R3 vec", 32'(vec_o), 32'h3B);
        wr(2'd2, 4'h1);
        accept();
        check("R7 nmi cleared", 32'(pend_o), 0);
        check("R8 nmi keeps mie", 32'(mie_o), 1);
        wr(2'd2, 4'h0);
    endtask

    task automatic t_vectors();
        wr(2'd0, 4'hF);
        wr(2'd1, 4'h3);
        for (int i = 1; i < 7; i++) begin
            pulse(7'(1 << i));
            wr(2'd2, 4'h1);
            check("R5 vec", 32'(vec_o), 32'(exp_vec[i]));
            accept();
            check("R7 pend after accept", 32'(pend_o), 0);
            check("R8 mie after accept", 32'(mie_o), 0);
        end
    endtask

    task automatic t_priority();
        pulse(7'h7E);
        wr(2'd2, 4'h1);
        check("R6 ext0 first", 32'(vec_o), 32'h38);
        pulse(7'h01);
        check("R6 nmi over all", 32'(vec_o), 32'h3B);
        accept();
        check("R7 only nmi cleared", 32'(pend_o), 32'h7E);
        check("R6 next is ext0", 32'(vec_o), 32'h38);
        accept();
        check("R7 only ext0 cleared", 32'(pend_o), 32'h7C);
        check("R8 irq off", 32'(irq_o), 0);
        for (int i = 2; i < 7; i++) wr(2'd3, 4'(i));
        check("R10 sw clear", 32'(pend_o), 0);
    endtask

    task automatic t_idle_ack();
        pulse(7'h40);
        check("R9 irq low", 32'(irq_o), 0);
        accept();
        check("R9 pend kept", 32'(pend_o), 32'h40);
        check("R9 mie kept", 32'(mie_o), 0);
    endtask

    task automatic t_clear_edges();
        wr(2'd3, 4'h7);
        check("R10 index7 no effect", 32'(pend_o), 32'h40);
        sw_we_i = 1'b1; sw_sel_i = 2'd3; sw_wdata_i = 4'h6; req_i = 7'h40;
        tick();
        sw_we_i = 1'b0; req_i = '0;
        check("R10 request wins", 32'(pend_o), 32'h40);
        wr(2'd3, 4'h6);
        check("R10 clear idx6", 32'(pend_o), 0);
    endtask

    task automatic t_hi_enables();
        wr(2'd0, 4'h0);
        wr(2'd1, 4'hC);
        pulse(7'h20);
        wr(2'd2, 4'h1);
        check("R4 upper bits ignored", 32'(irq_o), 0);
        wr(2'd1, 4'h2);
        check("R4 t16 still off", 32'(irq_o), 0);
        pulse(7'h40);
        check("R4 t1 enabled", 32'(irq_o), 1);
        check("R4 t1 vec", 32'(vec_o), 32'h23);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_hold_then_take();
        t_nmi();
        t_vectors();
        t_priority();
        t_idle_ack();
        t_clear_edges();
        t_hi_enables();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule